// File: doc/BRIEF.md
# Register Bank Context Switch Unit

This unit owns the context pointer that places a CPU's sixteen general-purpose registers inside a larger register memory. It also owns a small system stack used when interrupts enter and leave. A service routine gets its own register set in one step. The switch instruction saves the running base on the stack and loads an immediate base. Every register reference after that resolves against the new base. The routine pops the saved base before it returns, which brings back the interrupted program's registers. The unit never clears a bank, so a routine that switches to the same base again finds its registers as it left them.

Interrupt entry pushes the status words onto the stack one per cycle. Return pops them in the opposite order. A segmentation-disable input removes the segment word from both sequences. The stack pointer moves in byte steps of two. Any operation whose full sequence would move the pointer past the lower limit input or the upper limit input is refused as a whole and reported.

The unit presents a byte address for the register selected by the current instruction. It also flags the instruction that immediately follows a switch if that instruction names a general-purpose register.

Top module: `ctx_bank_unit`

## Requirements
- R1: After reset, cp is 16'hFC00, sp is 16'h0200, and busy, gpr_hazard, ret_valid, stk_ovf and stk_unf are all 0.
- R2: gpr_addr always equals cp + 2*gpr_num modulo 2^16, so register n of a bank is the 16-bit word at byte offset 2n. The output follows cp and gpr_num in the same cycle.
- R3: A switch (instr_op 3'd1) accepted while idle does four things in one cycle. It writes the old cp to the stack word at sp-2, lowers sp by 2, loads cp with instr_imm, and leaves busy low.
- R4: gpr_hazard is high in the cycle an instruction is accepted if that instruction has gpr_use set and the previously accepted instruction was a completed switch. Idle cycles in between do not matter. Otherwise gpr_hazard is 0.
- R5: An entry (instr_op 3'd2) pushes st_psw, then st_seg, then st_ip, one word per cycle, and lowers sp by 6. If seg_dis is 1 it pushes only st_psw and then st_ip, and lowers sp by 4. busy is high until the last push is done.
- R6: A return (instr_op 3'd4) pops the ip word, then the seg word, then the psw word, one per cycle, into ret_ip, ret_seg and ret_psw. It then pulses ret_valid for one cycle. If seg_dis is 1 the seg word is skipped and ret_seg keeps its previous value. sp rises by 6, or by 4 when the seg word is skipped.
- R7: A pointer restore (instr_op 3'd3) loads cp from the top stack word and raises sp by 2 in one cycle. Nested switches followed by restores give back each earlier cp exactly.
- R8: An operation whose pushes would take sp below ovf_lim is refused whole. cp, sp and the stack stay unchanged, and stk_ovf pulses high for one cycle.
- R9: An operation whose pops would take sp above unf_lim is refused whole. cp, sp and the ret outputs stay unchanged, and stk_unf pulses high for one cycle.
- R10: instr_valid is ignored while busy is high. An instruction presented then changes neither cp nor the ongoing sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_valid | input | 1 | An instruction is presented |
| instr_op | input | 3 | 0 none, 1 switch, 2 entry, 3 pointer restore, 4 return |
| instr_imm | input | 16 | New bank base for a switch |
| gpr_use | input | 1 | The instruction references a general-purpose register |
| gpr_num | input | 4 | Register number |
| seg_dis | input | 1 | Skip the segment word on entry and return |
| st_psw | input | 16 | Status word to save at entry |
| st_seg | input | 16 | Segment word to save at entry |
| st_ip | input | 16 | Instruction pointer to save at entry |
| ovf_lim | input | 16 | Lowest legal stack pointer |
| unf_lim | input | 16 | Highest legal stack pointer |
| busy | output | 1 | A multi-word sequence is running |
| cp | output | 16 | Context pointer |
| sp | output | 16 | Stack pointer |
| gpr_addr | output | 16 | Byte address of the referenced register |
| gpr_hazard | output | 1 | Register reference right after a switch |
| ret_valid | output | 1 | One-cycle pulse when a return completes |
| ret_psw | output | 16 | Restored status word |
| ret_seg | output | 16 | Restored segment word |
| ret_ip | output | 16 | Restored instruction pointer |
| stk_ovf | output | 1 | Pulse on a refused push sequence |
| stk_unf | output | 1 | Pulse on a refused pop sequence |

## Verification
The bench sweeps all sixteen register numbers at every nesting level and across a base that wraps at the top of the address space. A design with the wrong scaling or a base that is not restored would point registers into the wrong bank. It nests an entry with the segment word and one without it, then unwinds both. Popping in push order, or ignoring seg_dis on one side only, would leave ip, psw and seg swapped or shifted by a word. The hazard cases separate a register use right after a switch, a use after idle cycles, and a use behind an intervening instruction, so a flag tied to clock cycles instead of instructions shows up. Refused sequences are placed so that only part of the sequence would fit. A design that checks one word at a time would push partial state instead of leaving sp untouched.

// File: rtl/ctxu_pkg.sv
package ctxu_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_SWITCH = 3'd1,
        OP_ENTRY  = 3'd2,
        OP_POPCP  = 3'd3,
        OP_RETI   = 3'd4
    } ctx_op_e;

    typedef enum logic [1:0] {
        W_PSW = 2'd0,
        W_SEG = 2'd1,
        W_IP  = 2'd2
    } word_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PUSH = 2'd1,
        PH_POP  = 2'd2
    } phase_e;

    // number of status words moved for one entry or return
    function automatic logic [1:0] status_words(input logic skip_seg);
        return skip_seg ? 2'd2 : 2'd3;
    endfunction

endpackage

// File: rtl/ctxu_stack.sv
module ctxu_stack #(
    parameter int          DW       = 16,
    parameter int          DEPTH    = 16,
    parameter logic [15:0] SP_RESET = 16'h0200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_push,
    input  logic          chk_pop,
    input  logic [1:0]    chk_n,
    input  logic          push_en,
    input  logic          pop_en,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ovf_lim,
    input  logic [DW-1:0] unf_lim,
    output logic [DW-1:0] sp_o,
    output logic [DW-1:0] top_o,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DW-1:0] sp;
        logic          ovf;
        logic          unf;
    } stk_state_t;

    stk_state_t    s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW:0]   span, below, above;
    logic [DW-1:0] sp_dec, sp_inc;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    always_comb begin
        span    = {{(DW-2){1'b0}}, chk_n, 1'b0};
        below   = {1'b0, s_q.sp} - span;
        above   = {1'b0, s_q.sp} + span;
        push_ok = !below[DW] && (below[DW-1:0] >= ovf_lim);
        pop_ok  = (above <= {1'b0, unf_lim});
        sp_dec  = s_q.sp - DW'(2);
        sp_inc  = s_q.sp + DW'(2);
        wr_idx  = sp_dec[IDX_W:1];
        rd_idx  = s_q.sp[IDX_W:1];
        top_o   = mem_q[rd_idx];

        s_d     = s_q;
        s_d.ovf = chk_push && !push_ok;
        s_d.unf = chk_pop && !pop_ok;
        if (push_en)     s_d.sp = sp_dec;
        else if (pop_en) s_d.sp = sp_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sp  <= SP_RESET[DW-1:0];
            s_q.ovf <= 1'b0;
            s_q.unf <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) mem_q[wr_idx] <= wdata;
    end

    assign sp_o  = s_q.sp;
    assign ovf_o = s_q.ovf;
    assign unf_o = s_q.unf;

    a_r5_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> sp_o == $past(sp_o) - DW'(2));
    a_r7_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> sp_o == $past(sp_o) + DW'(2));
    a_r8_refused_push: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_push && !push_ok) |=> (ovf_o && $stable(sp_o)));
    a_r9_refused_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_pop && !pop_ok) |=> (unf_o && $stable(sp_o)));

endmodule

// File: rtl/ctxu_seq.sv
module ctxu_seq
    import ctxu_pkg::*;
#(
    parameter int          DW       = 16,
    parameter logic [15:0] CP_RESET = 16'hFC00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [2:0]    instr_op,
    input  logic [DW-1:0] instr_imm,
    input  logic          seg_dis,
    input  logic [DW-1:0] st_psw,
    input  logic [DW-1:0] st_seg,
    input  logic [DW-1:0] st_ip,
    input  logic [DW-1:0] top_data,
    input  logic          push_ok,
    input  logic          pop_ok,
    output logic          chk_push,
    output logic          chk_pop,
    output logic [1:0]    chk_n,
    output logic          push_en,
    output logic          pop_en,
    output logic [DW-1:0] push_data,
    output logic [DW-1:0] cp_o,
    output logic          busy_o,
    output logic          accept_o,
    output logic          sw_fire_o,
    output logic          ret_valid_o,
    output logic [DW-1:0] ret_psw_o,
    output logic [DW-1:0] ret_seg_o,
    output logic [DW-1:0] ret_ip_o
);
    typedef struct packed {
        phase_e        phase;
        word_kind_e    kind;
        logic [DW-1:0] cp;
        logic [DW-1:0] hold_seg;
        logic [DW-1:0] hold_ip;
        logic [DW-1:0] ret_psw;
        logic [DW-1:0] ret_seg;
        logic [DW-1:0] ret_ip;
        logic          ret_valid;
    } seq_state_t;

    seq_state_t s_d, s_q;
    ctx_op_e    op;

    always_comb begin
        op        = ctx_op_e'(instr_op);
        s_d       = s_q;
        s_d.ret_valid = 1'b0;
        chk_push  = 1'b0;
        chk_pop   = 1'b0;
        chk_n     = 2'd1;
        push_en   = 1'b0;
        pop_en    = 1'b0;
        push_data = s_q.cp;
        sw_fire_o = 1'b0;
        accept_o  = instr_valid && (s_q.phase == PH_IDLE);

        unique case (s_q.phase)
            PH_IDLE: begin
                if (accept_o) begin
                    unique case (op)
                        OP_SWITCH: begin
                            chk_push = 1'b1;
                            if (push_ok) begin
                                push_en   = 1'b1;
                                push_data = s_q.cp;
                                s_d.cp    = instr_imm;
                                sw_fire_o = 1'b1;
                            end
                        end
                        OP_ENTRY: begin
                            chk_push = 1'b1;
                            chk_n    = status_words(seg_dis);
                            if (push_ok) begin
                                push_en      = 1'b1;
                                push_data    = st_psw;
                                s_d.hold_seg = st_seg;
                                s_d.hold_ip  = st_ip;
                                s_d.kind     = seg_dis ? W_IP : W_SEG;
                                s_d.phase    = PH_PUSH;
                            end
                        end
                        OP_POPCP: begin
                            chk_pop = 1'b1;
                            if (pop_ok) begin
                                pop_en = 1'b1;
                                s_d.cp = top_data;
                            end
                        end
                        OP_RETI: begin
                            chk_pop = 1'b1;
                            chk_n   = status_words(seg_dis);
                            if (pop_ok) begin
                                pop_en     = 1'b1;
                                s_d.ret_ip = top_data;
                                s_d.kind   = seg_dis ? W_PSW : W_SEG;
                                s_d.phase  = PH_POP;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            PH_PUSH: begin
                push_en = 1'b1;
                if (s_q.kind == W_SEG) begin
                    push_data = s_q.hold_seg;
                    s_d.kind  = W_IP;
                end else begin
                    push_data = s_q.hold_ip;
                    s_d.phase = PH_IDLE;
                end
            end
            PH_POP: begin
                pop_en = 1'b1;
                if (s_q.kind == W_SEG) begin
                    s_d.ret_seg = top_data;
                    s_d.kind    = W_PSW;
                end else begin
                    s_d.ret_psw   = top_data;
                    s_d.ret_valid = 1'b1;
                    s_d.phase     = PH_IDLE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase     <= PH_IDLE;
            s_q.kind      <= W_PSW;
            s_q.cp        <= CP_RESET[DW-1:0];
            s_q.hold_seg  <= '0;
            s_q.hold_ip   <= '0;
            s_q.ret_psw   <= '0;
            s_q.ret_seg   <= '0;
            s_q.ret_ip    <= '0;
            s_q.ret_valid <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cp_o        = s_q.cp;
    assign busy_o      = (s_q.phase != PH_IDLE);
    assign ret_valid_o = s_q.ret_valid;
    assign ret_psw_o   = s_q.ret_psw;
    assign ret_seg_o   = s_q.ret_seg;
    assign ret_ip_o    = s_q.ret_ip;

    a_r3_switch_loads: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fire_o |=> (cp_o == $past(instr_imm)) && !busy_o);
    a_r6_ret_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_o |=> !ret_valid_o);
    a_r10_busy_holds_cp: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(cp_o));

endmodule

// File: rtl/ctxu_gpr_port.sv
module ctxu_gpr_port #(
    parameter int DW   = 16,
    parameter int RN_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            sw_fire,
    input  logic            gpr_use,
    input  logic [RN_W-1:0] gpr_num,
    input  logic [DW-1:0]   cp,
    output logic [DW-1:0]   gpr_addr,
    output logic            hazard
);
    typedef struct packed {
        logic last_sw;
    } port_state_t;

    port_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        gpr_addr = cp + {{(DW-RN_W-1){1'b0}}, gpr_num, 1'b0};
        hazard   = accept && gpr_use && s_q.last_sw;
        if (accept) s_d.last_sw = sw_fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.last_sw <= 1'b0;
        else        s_q <= s_d;
    end

    a_r4_hazard_after_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_fire ##1 (accept && gpr_use)) |-> hazard);
    a_r4_no_hazard_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> !hazard);

endmodule

// File: rtl/ctx_bank_unit.sv
module ctx_bank_unit #(
    parameter int          DW        = 16,
    parameter int          RN_W      = 4,
    parameter int          STK_DEPTH = 16,
    parameter logic [15:0] CP_RESET  = 16'hFC00,
    parameter logic [15:0] SP_RESET  = 16'h0200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [2:0]      instr_op,
    input  logic [DW-1:0]   instr_imm,
    input  logic            gpr_use,
    input  logic [RN_W-1:0] gpr_num,
    input  logic            seg_dis,
    input  logic [DW-1:0]   st_psw,
    input  logic [DW-1:0]   st_seg,
    input  logic [DW-1:0]   st_ip,
    input  logic [DW-1:0]   ovf_lim,
    input  logic [DW-1:0]   unf_lim,
    output logic            busy,
    output logic [DW-1:0]   cp,
    output logic [DW-1:0]   sp,
    output logic [DW-1:0]   gpr_addr,
    output logic            gpr_hazard,
    output logic            ret_valid,
    output logic [DW-1:0]   ret_psw,
    output logic [DW-1:0]   ret_seg,
    output logic [DW-1:0]   ret_ip,
    output logic            stk_ovf,
    output logic            stk_unf
);
    logic          chk_push, chk_pop, push_en, pop_en, push_ok, pop_ok;
    logic          accept, sw_fire;
    logic [1:0]    chk_n;
    logic [DW-1:0] push_data, top_data;

    ctxu_seq #(.DW(DW), .CP_RESET(CP_RESET)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_op(instr_op), .instr_imm(instr_imm),
        .seg_dis(seg_dis), .st_psw(st_psw), .st_seg(st_seg), .st_ip(st_ip),
        .top_data(top_data), .push_ok(push_ok), .pop_ok(pop_ok),
        .chk_push(chk_push), .chk_pop(chk_pop), .chk_n(chk_n),
        .push_en(push_en), .pop_en(pop_en), .push_data(push_data),
        .cp_o(cp), .busy_o(busy), .accept_o(accept), .sw_fire_o(sw_fire),
        .ret_valid_o(ret_valid), .ret_psw_o(ret_psw), .ret_seg_o(ret_seg),
        .ret_ip_o(ret_ip)
    );

    ctxu_stack #(.DW(DW), .DEPTH(STK_DEPTH), .SP_RESET(SP_RESET)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .chk_push(chk_push), .chk_pop(chk_pop), .chk_n(chk_n),
        .push_en(push_en), .pop_en(pop_en), .wdata(push_data),
        .ovf_lim(ovf_lim), .unf_lim(unf_lim),
        .sp_o(sp), .top_o(top_data), .push_ok(push_ok), .pop_ok(pop_ok),
        .ovf_o(stk_ovf), .unf_o(stk_unf)
    );

    ctxu_gpr_port #(.DW(DW), .RN_W(RN_W)) u_gpr (
        .clk(clk), .rst_n(rst_n), .accept(accept), .sw_fire(sw_fire),
        .gpr_use(gpr_use), .gpr_num(gpr_num), .cp(cp),
        .gpr_addr(gpr_addr), .hazard(gpr_hazard)
    );

    a_r1_sp_even: assert property (@(posedge clk) disable iff (!rst_n)
        sp[0] == SP_RESET[0]);

endmodule

// File: tb/test_ctx_bank_unit.sv
module test_ctx_bank_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [2:0]  instr_op = 3'd0;
    logic [15:0] instr_imm = '0;
    logic        gpr_use = 1'b0;
    logic [3:0]  gpr_num = '0;
    logic        seg_dis = 1'b0;
    logic [15:0] st_psw = '0, st_seg = '0, st_ip = '0;
    logic [15:0] ovf_lim = 16'h0100, unf_lim = 16'h0200;
    logic        busy, gpr_hazard, ret_valid, stk_ovf, stk_unf;
    logic [15:0] cp, sp, gpr_addr, ret_psw, ret_seg, ret_ip;

    int checks = 0;
    int errors = 0;
    logic        haz_seen;
    logic [15:0] exp_sp;

    always #4 clk = ~clk;

    ctx_bank_unit i_ctx_bank_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_imm(instr_imm), .gpr_use(gpr_use), .gpr_num(gpr_num),
        .seg_dis(seg_dis), .st_psw(st_psw), .st_seg(st_seg), .st_ip(st_ip),
        .ovf_lim(ovf_lim), .unf_lim(unf_lim), .busy(busy), .cp(cp), .sp(sp),
        .gpr_addr(gpr_addr), .gpr_hazard(gpr_hazard), .ret_valid(ret_valid),
        .ret_psw(ret_psw), .ret_seg(ret_seg), .ret_ip(ret_ip),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_instr(input logic [2:0] op, input logic [15:0] imm,
                            input logic use_g, input logic [3:0] num);
        @(negedge clk);
        instr_valid = 1'b1; instr_op = op; instr_imm = imm;
        gpr_use = use_g; gpr_num = num;
        #1 haz_seen = gpr_hazard;
        @(negedge clk);
        instr_valid = 1'b0; gpr_use = 1'b0; instr_op = 3'd0;
        while (busy) @(negedge clk);
    endtask

    task automatic sweep_bank(input string req, input logic [15:0] base);
        for (int n = 0; n < 16; n++) begin
            gpr_num = 4'(n);
            #1 chk(req, gpr_addr, 32'(16'(base + 16'(2 * n))));
        end
    endtask

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cp", cp, 16'hFC00);
        chk("R1 sp", sp, 16'h0200);
        chk("R1 flags", {busy, gpr_hazard, ret_valid, stk_ovf, stk_unf}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        exp_sp = 16'h0200;
        sweep_bank("R2 base bank", 16'hFC00);

        // R5 level-1 entry with segment word
        seg_dis = 1'b0; st_psw = 16'h1111; st_seg = 16'h2222; st_ip = 16'h3333;
        do_instr(3'd2, 0, 0, 0);
        exp_sp -= 6;
        chk("R5 sp after 3-word entry", sp, exp_sp);
        // R3 switch to first routine bank
        do_instr(3'd1, 16'hF600, 0, 0);
        exp_sp -= 2;
        chk("R3 cp loaded", cp, 16'hF600);
        chk("R3 sp", sp, exp_sp);
        // R4 register use right after switch
        do_instr(3'd0, 0, 1, 4'd5);
        chk("R4 hazard right after switch", haz_seen, 1);
        do_instr(3'd0, 0, 1, 4'd5);
        chk("R4 no hazard second instr", haz_seen, 0);
        sweep_bank("R2 level1 bank", 16'hF600);

        // R5 level-2 entry without segment word
        seg_dis = 1'b1; st_psw = 16'hA0A0; st_seg = 16'hBEEF; st_ip = 16'hC0C0;
        do_instr(3'd2, 0, 0, 0);
        exp_sp -= 4;
        chk("R5 sp after 2-word entry", sp, exp_sp);
        do_instr(3'd1, 16'hF800, 0, 0);
        exp_sp -= 2;
        // R4 use after idle cycles is still the next instruction
        repeat (3) @(negedge clk);
        do_instr(3'd0, 0, 1, 4'd0);
        chk("R4 hazard after idle gap", haz_seen, 1);
        sweep_bank("R2 level2 bank", 16'hF800);

        // unwind level 2
        do_instr(3'd3, 0, 0, 0);
        exp_sp += 2;
        chk("R7 cp level1 restored", cp, 16'hF600);
        do_instr(3'd4, 0, 0, 0);
        exp_sp += 4;
        chk("R6 ret_valid 2-word", ret_valid, 1);
        chk("R6 ret_ip", ret_ip, 16'hC0C0);
        chk("R6 ret_psw", ret_psw, 16'hA0A0);
        chk("R6 ret_seg untouched", ret_seg, 16'h0000);
        chk("R6 sp", sp, exp_sp);
        @(negedge clk);
        chk("R6 pulse one cycle", ret_valid, 0);
        sweep_bank("R2 level1 again", 16'hF600);

        // unwind level 1
        seg_dis = 1'b0;
        do_instr(3'd3, 0, 0, 0);
        exp_sp += 2;
        chk("R7 cp original restored", cp, 16'hFC00);
        do_instr(3'd4, 0, 0, 0);
        exp_sp += 6;
        chk("R6 ret_ip l1", ret_ip, 16'h3333);
        chk("R6 ret_seg l1", ret_seg, 16'h2222);
        chk("R6 ret_psw l1", ret_psw, 16'h1111);
        chk("R6 sp home", sp, 16'h0200);

        // R4 switch then a non-register instruction clears the hazard
        do_instr(3'd1, 16'hFFF0, 0, 0);
        do_instr(3'd0, 0, 0, 0);
        do_instr(3'd0, 0, 1, 4'd3);
        chk("R4 hazard cleared by intervening instr", haz_seen, 0);
        sweep_bank("R2 wraparound bank", 16'hFFF0);
        do_instr(3'd3, 0, 0, 0);
        chk("R7 restore after wrap", cp, 16'hFC00);

        // R9 underflow at home
        do_instr(3'd4, 0, 0, 0);
        chk("R9 unf pulse reti", stk_unf, 1);
        chk("R9 sp unchanged", sp, 16'h0200);
        chk("R9 no ret_valid", ret_valid, 0);
        do_instr(3'd3, 0, 0, 0);
        chk("R9 unf pulse popcp", stk_unf, 1);
        chk("R9 cp unchanged", cp, 16'hFC00);

        // R8 overflow: only 2 words of room
        ovf_lim = 16'h01FC;
        seg_dis = 1'b0;
        do_instr(3'd2, 0, 0, 0);
        chk("R8 ovf pulse 3-word entry", stk_ovf, 1);
        chk("R8 sp unchanged", sp, 16'h0200);
        seg_dis = 1'b1; st_psw = 16'h0101; st_ip = 16'h0202;
        do_instr(3'd2, 0, 0, 0);
        chk("R8 2-word entry fits", {stk_ovf, sp}, {1'b0, 16'h01FC});
        do_instr(3'd1, 16'h1234, 0, 0);
        chk("R8 ovf pulse switch", stk_ovf, 1);
        chk("R8 cp unchanged", cp, 16'hFC00);
        do_instr(3'd4, 0, 0, 0);
        chk("R8 stack intact ip", ret_ip, 16'h0202);
        chk("R8 stack intact psw", ret_psw, 16'h0101);
        ovf_lim = 16'h0100;

        // R10 instruction during busy is ignored
        seg_dis = 1'b0; st_psw = 16'h4444; st_seg = 16'h5555; st_ip = 16'h6666;
        @(negedge clk);
        instr_valid = 1'b1; instr_op = 3'd2;
        @(negedge clk);
        chk("R10 busy during entry", busy, 1);
        instr_op = 3'd1; instr_imm = 16'h1234;
        @(negedge clk);
        @(negedge clk);
        instr_valid = 1'b0; instr_op = 3'd0;
        chk("R10 cp unchanged", cp, 16'hFC00);
        chk("R10 sp entry only", sp, 16'h01FA);
        do_instr(3'd4, 0, 0, 0);
        chk("R10 ret_ip", ret_ip, 16'h6666);
        chk("R10 ret_seg", ret_seg, 16'h5555);
        chk("R10 ret_psw", ret_psw, 16'h4444);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule